// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of 32 pins behind a small word-addressed register bus. Software sets an output value and a drive enable for each pin, and reads back the synchronised pad level separately from the stored output value. Every pad input passes through a two-flop synchroniser before any logic uses it.

Each pin has its own interrupt condition. A 2-bit mode field picks low level, high level, rising edge or falling edge. A separate per-pin override bit turns on detection of both edges. Detected conditions set bits in a sticky pending register that software clears by writing ones. A mask register gates the pending bits onto two interrupt lines, one for the lower half of the pins and one for the upper half.

Top module: `gpio_port32`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and both interrupt lines are low; the pending register then follows the detection rules from the first clock.
- R2: Word index 0 (byte address 0x00) holds the output value and reads back what was last written, not the pad level; word index 1 (0x04) holds the drive enables. `pad_out` equals the output value and `pad_oe` equals the drive enables, one bit per pin.
- R3: Word index 2 (0x08) is read-only and returns the pad level after two clock edges of synchronisation; a pad change made between edges E0 and E1 is visible in a read sampled after E2 but not after E1.
- R4: The mode of pin p is the 2-bit field at bit 2*(p mod 16) of word index 3 (0x0C) for pins 0 to 15 and of word index 4 (0x10) for pins 16 to 31, coded 0 low level, 1 high level, 2 rising edge, 3 falling edge. With all fields at reset (0) and pads low, every pending bit is set.
- R5: An edge is the synchronised level differing from its value one clock earlier; a pin in rising mode ignores a falling edge and a pin in falling mode ignores a rising edge. The pending bit is set on the edge after the synchronised level changes.
- R6: A 1 in bit p of word index 7 (0x1C) makes pin p detect both rising and falling edges, ignoring its mode field.
- R7: Word index 6 (0x18) is the pending register: writing a 1 to a bit clears that bit only, writing all ones clears every bit, writing 0 bits leaves them unchanged, and pending bits stay set until cleared.
- R8: In level mode a pending bit is set again on every clock the level holds, so a clear in that state has no lasting effect; when a detection and a clear meet in one cycle the bit ends set.
- R9: Word index 5 (0x14) is the mask, 1 enables a pin; `irq_lo` is the OR of pending-and-enabled bits of pins 0 to 15 and `irq_hi` that of pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte address, word index in bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Drive enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
Detection is tried with single rising and falling pad transitions on pins set to the matching mode, to the opposite mode and to the both-edges override, which separates a correct mode decode from one that fires on any change or reads the wrong word half. A pad held at an active level while software clears its bit tells a re-arming level detector from a one-shot one. Pending bits on pins in both halves, cleared one at a time under different masks, separate the two interrupt lines and a per-bit clear from a whole-register clear.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int W_DATA = 0;
  localparam int W_DIR  = 1;
  localparam int W_PAD  = 2;
  localparam int W_CFGL = 3;
  localparam int W_CFGH = 4;
  localparam int W_MASK = 5;
  localparam int W_PEND = 6;
  localparam int W_BOTH = 7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  function automatic logic pin_event(input logic [1:0] mode, input logic both,
                                     input logic cur, input logic prev);
    logic hit;
    if (both) begin
      hit = cur ^ prev;
    end else begin
      unique case (trig_e'(mode))
        TRIG_LOW:  hit = ~cur;
        TRIG_HIGH: hit = cur;
        TRIG_RISE: hit = cur & ~prev;
        default:   hit = ~cur & prev;
      endcase
    end
    return hit;
  endfunction
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

  always_comb begin
    s1_d = din;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/gp_detect.sv
module gp_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] cfg_lo,
  input  logic [NPIN-1:0] cfg_hi,
  input  logic [NPIN-1:0] both,
  output logic [NPIN-1:0] evt
);
  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] prev_q, prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int OFF = 2 * (p % HALF);
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = cfg_lo[OFF +: 2];
    end else begin : g_hi
      assign mode = cfg_hi[OFF +: 2];
    end
    assign evt[p] = gp_pkg::pin_event(mode, both[p], lvl[p], prev_q[p]);
  end
endmodule

// File: rtl/gp_regs.sv
module gp_regs #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_lvl,
  input  logic [NPIN-1:0] evt,
  output logic [NPIN-1:0] data_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] cfg_lo_q,
  output logic [NPIN-1:0] cfg_hi_q,
  output logic [NPIN-1:0] both_q,
  output logic            irq_lo,
  output logic            irq_hi
);
  import gp_pkg::*;
  localparam int HALF = NPIN / 2;
  localparam int IW   = AW - 2;

  logic [IW-1:0]   word;
  logic            wr;
  logic            data_en, dir_en, cfgl_en, cfgh_en, mask_en, both_en;
  logic [NPIN-1:0] mask_q, pend_q, pend_d, clr;
  logic [NPIN-1:0] gated;

  always_comb begin
    word    = bus_addr[AW-1:2];
    wr      = bus_en & bus_we;
    data_en = wr && (int'(word) == W_DATA);
    dir_en  = wr && (int'(word) == W_DIR);
    cfgl_en = wr && (int'(word) == W_CFGL);
    cfgh_en = wr && (int'(word) == W_CFGH);
    mask_en = wr && (int'(word) == W_MASK);
    both_en = wr && (int'(word) == W_BOTH);
    clr     = (wr && (int'(word) == W_PEND)) ? bus_wdata : '0;
    pend_d  = (pend_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      pend_q   <= '0;
    end else begin
      if (data_en) data_q   <= bus_wdata;
      if (dir_en)  dir_q    <= bus_wdata;
      if (cfgl_en) cfg_lo_q <= bus_wdata;
      if (cfgh_en) cfg_hi_q <= bus_wdata;
      if (mask_en) mask_q   <= bus_wdata;
      if (both_en) both_q   <= bus_wdata;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (int'(word))
      W_DATA:  bus_rdata = data_q;
      W_DIR:   bus_rdata = dir_q;
      W_PAD:   bus_rdata = pad_lvl;
      W_CFGL:  bus_rdata = cfg_lo_q;
      W_CFGH:  bus_rdata = cfg_hi_q;
      W_MASK:  bus_rdata = mask_q;
      W_PEND:  bus_rdata = pend_q;
      default: bus_rdata = both_q;
    endcase
  end

  assign gated  = pend_q & mask_q;
  assign irq_lo = |gated[HALF-1:0];
  assign irq_hi = |gated[NPIN-1:HALF];

  // R7: a pending bit survives a cycle with no clear written to it
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));

  // R7: a written one clears the bit unless a detection arrives with it
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (int'(word) == W_PEND)) |=> ((pend_q & $past(bus_wdata & ~evt)) == '0));

  // R8: a detection always leaves its bit set, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R2: the drive enables follow a write to word 1
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en |=> (dir_q == $past(bus_wdata)));

  // R2: the output value follows a write to word 0
  p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |=> (data_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_port32.sv
module gpio_port32 #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  logic            rst_m_q, rst_s_q;
  logic [NPIN-1:0] lvl, evt, data_q, dir_q, cfg_lo_q, cfg_hi_q, both_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  gp_sync #(.W(NPIN)) u_sync (
    .clk (clk), .rst_n (rst_s_q), .din (pad_in), .dout (lvl)
  );

  gp_detect #(.NPIN(NPIN)) u_det (
    .clk (clk), .rst_n (rst_s_q), .lvl (lvl), .cfg_lo (cfg_lo_q),
    .cfg_hi (cfg_hi_q), .both (both_q), .evt (evt)
  );

  gp_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk (clk), .rst_n (rst_s_q), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pad_lvl (lvl), .evt (evt), .data_q (data_q), .dir_q (dir_q),
    .cfg_lo_q (cfg_lo_q), .cfg_hi_q (cfg_hi_q), .both_q (both_q),
    .irq_lo (irq_lo), .irq_hi (irq_hi)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: tb/sim_gpio_port32.sv
`timescale 1ns/1ps
module sim_gpio_port32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  logic  mon_req = 1'b0;

  always #4 clk = ~clk;

  gpio_port32 u0 (
    .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
    .irq_lo (irq_lo), .irq_hi (irq_hi)
  );

  // monitor: compares the oldest expected item against the ports
  always @(negedge clk) begin
    if (mon_req && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {30'd0, irq_hi, irq_lo};
        2: act = pad_oe;
        default: act = pad_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 5'(idx * 4);
    push(0, exp, tag);
  endtask

  task automatic port(input int kind, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    push(kind, exp, tag);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'(idx * 4); bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(2); #1 rst_n = 1'b1;
    idle(3);
    // R1 reset state
    port(2, 32'h0, "R1 pad_oe reset");
    port(3, 32'h0, "R1 pad_out reset");
    port(1, 32'h0, "R1 irq reset");
    rd(0, 32'h0, "R1 data reset");
    rd(1, 32'h0, "R1 dir reset");
    rd(3, 32'h0, "R1 cfg_lo reset");
    rd(5, 32'h0, "R1 mask reset");
    rd(7, 32'h0, "R1 both reset");
    // R4 default mode is low level: every pin pending
    rd(6, 32'hFFFF_FFFF, "R4 low-level default pending");
    // all pins rising, then clear everything
    wr(3, 32'hAAAA_AAAA);
    wr(4, 32'hAAAA_AAAA);
    wr(6, 32'hFFFF_FFFF);
    rd(6, 32'h0, "R7 clear all");
    rd(4, 32'hAAAA_AAAA, "R4 cfg_hi readback");
    // R2 output value and drive enable
    wr(0, 32'hA5A5_3C3C);
    rd(0, 32'hA5A5_3C3C, "R2 data readback");
    rd(2, 32'h0, "R2 pad status not data");
    port(2, 32'h0, "R2 pad_oe before dir");
    wr(1, 32'hFFFF_0000);
    port(2, 32'hFFFF_0000, "R2 pad_oe from dir");
    port(3, 32'hA5A5_3C3C, "R2 pad_out from data");
    // R3 synchroniser latency; R5 rising pins 0 and 31
    @(posedge clk); #1 pad_in = 32'h8000_0001;
    rd(2, 32'h0, "R3 not visible after one edge");
    rd(2, 32'h8000_0001, "R3 visible after two edges");
    rd(6, 32'h8000_0001, "R5 rising edge pending");
    // R9 mask and split lines
    port(1, 32'h0, "R9 masked off");
    wr(5, 32'h0000_0001);
    port(1, 32'h1, "R9 low line only");
    wr(5, 32'h8000_0001);
    port(1, 32'h3, "R9 both lines");
    wr(6, 32'h0000_0001);
    rd(6, 32'h8000_0000, "R7 single bit clear");
    port(1, 32'h2, "R9 high line only");
    wr(6, 32'h0);
    rd(6, 32'h8000_0000, "R7 zero write no effect");
    wr(6, 32'hFFFF_FFFF);
    port(1, 32'h0, "R9 lines drop after clear");
    // R4 falling mode on pin 20 (upper word field bits 9:8)
    wr(4, 32'hAAAA_ABAA);
    wr(6, 32'hFFFF_FFFF);
    @(posedge clk); #1 pad_in = 32'h8010_0001;
    idle(4);
    rd(6, 32'h0, "R5 falling pin ignores rise");
    @(posedge clk); #1 pad_in = 32'h8000_0000;
    idle(4);
    rd(6, 32'h0010_0000, "R4 R5 falling pin20 only");
    wr(5, 32'h0010_0000);
    port(1, 32'h2, "R9 pin20 on high line");
    wr(6, 32'hFFFF_FFFF);
    // R6 both edges on pin 8
    wr(7, 32'h0000_0100);
    @(posedge clk); #1 pad_in = 32'h8000_0100;
    idle(4);
    rd(6, 32'h0000_0100, "R6 rise with both");
    wr(6, 32'h0000_0100);
    @(posedge clk); #1 pad_in = 32'h8000_0000;
    idle(4);
    rd(6, 32'h0000_0100, "R6 fall with both");
    wr(6, 32'hFFFF_FFFF);
    // R8 level high on pin 5 (lower word bits 11:10 = 1)
    wr(3, 32'hAAAA_A6AA);
    wr(6, 32'hFFFF_FFFF);
    rd(6, 32'h0, "R8 no level yet");
    @(posedge clk); #1 pad_in = 32'h8000_0020;
    idle(4);
    rd(6, 32'h0000_0020, "R8 level sets");
    wr(6, 32'h0000_0020);
    rd(6, 32'h0000_0020, "R8 clear does not stick");
    @(posedge clk); #1 pad_in = 32'h8000_0000;
    idle(4);
    wr(6, 32'h0000_0020);
    rd(6, 32'h0, "R8 clear after level gone");
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule